// File: doc/BRIEF.md
# Sector Burst DMA Mover

This block moves whole sectors between a 64-bit AXI4 memory master port and a 32-bit word stream that faces a serial storage link layer. A client starts a transfer with one request. The request gives a 32-bit byte address, a byte count that is a non-zero multiple of 512, a direction flag and a flag that permits large bursts. The engine cuts the transfer into AXI4 bursts of 512 or 2048 bytes. It keeps one burst in flight at a time. It pulses `done` once all bytes have moved.

Two FIFOs of 64-bit entries sit between the bus and the stream. The fetch FIFO takes AXI4 read data and hands it to the outgoing stream as 32-bit words. The store FIFO gathers pairs of incoming stream words into 64-bit beats for AXI4 write data. A burst is issued only when its FIFO can absorb or supply the whole burst, so the bus handshakes never stall on the FIFO.

The controller is one state machine with these states:
- `S_IDLE` waits for a request.
- `S_PLAN` picks the next burst size and waits for FIFO room or fill.
- `S_ADDR` presents the read or write address.
- `S_RDATA` takes read beats.
- `S_WDATA` sends write beats.
- `S_WRESP` waits for the write response.
- `S_DRAIN` waits for the fetch FIFO to empty.
- `S_FINISH` raises `done` for one cycle.

The state transitions are:
- `S_IDLE` to `S_PLAN` on a request.
- `S_PLAN` to `S_ADDR` when the FIFO condition holds.
- `S_PLAN` to `S_DRAIN` (read) or `S_FINISH` (write) when no bytes remain.
- `S_ADDR` to `S_RDATA` or `S_WDATA` on the address handshake.
- `S_RDATA` to `S_PLAN` on the beat that carries RLAST.
- `S_WDATA` to `S_WRESP` after the final beat.
- `S_WRESP` to `S_PLAN`, or to `S_FINISH` when nothing is left.
- `S_DRAIN` to `S_FINISH` once the fetch FIFO is empty.
- `S_FINISH` to `S_IDLE`.

Top module: `sector_dma`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `m_arvalid`, `m_awvalid`, `lk_out_valid` and `lk_in_ready` are all low.
- R2: The first burst starts at the request address, and each later burst starts where the previous one ended. When `req_wide` is 1 and at least 2048 bytes remain, the burst is 2048 bytes (length field 255). Otherwise the burst is 512 bytes (length field 63).
- R3: A read address is presented only when the fetch FIFO has free entries for every beat of that burst.
- R4: A write address is presented only when the store FIFO already holds every beat of that burst.
- R5: Each 64-bit beat maps to two stream words, and the low half (bits 31:0) is always the first of the pair. This holds in both directions.
- R6: WLAST is high on the final beat of each write burst and on no other beat.
- R7: For a write, `done` rises only after the write response of the final burst has been accepted.
- R8: For a read, `done` rises only after every word of the transfer has left on the outgoing stream.
- R9: `done` is high for exactly one cycle per transfer. A request that arrives while `busy` is high is ignored.
- R10: Once AR or AW valid is raised, it stays high, with its address and length unchanged, until ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start request strobe |
| req_addr | input | 32 | Sector-aligned byte address |
| req_bytes | input | 24 | Byte count, a multiple of 512 |
| req_to_mem | input | 1 | 1: stream to memory (write); 0: memory to stream (read) |
| req_wide | input | 1 | Permit 2048-byte bursts |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| m_araddr | output | 32 | Read burst address |
| m_arlen | output | 8 | Read beats minus one |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 64 | Read data |
| m_rlast | input | 1 | Final read beat |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_awaddr | output | 32 | Write burst address |
| m_awlen | output | 8 | Write beats minus one |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 64 | Write data |
| m_wlast | output | 1 | Final write beat |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| lk_out_data | output | 32 | Outgoing stream word |
| lk_out_valid | output | 1 | Outgoing word valid |
| lk_out_ready | input | 1 | Outgoing word accepted |
| lk_in_data | input | 32 | Incoming stream word |
| lk_in_valid | input | 1 | Incoming word valid |
| lk_in_ready | output | 1 | Incoming word accepted |

## Verification
A FIFO can be written on the bus side and read on the stream side in the same cycle. In a read, an R beat enters the fetch FIFO while the stream takes a high half. In a write, a word pair lands in the store FIFO while a W beat leaves it. The bench provokes this collision with irregular, mutually prime ready and valid patterns on the bus model and on the stream model. It judges the result by the order and value of every word and every beat: each carries its own byte address, so a lost, duplicated or swapped half is seen at once. A stalled stream also makes the room check in `S_PLAN` coincide with the first pops, and the bench checks that the second read burst waits for free entries.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_PLAN, S_ADDR, S_RDATA, S_WDATA, S_WRESP, S_DRAIN, S_FINISH
    } sdma_state_t;
endpackage

// File: rtl/sdma_fifo.sv
module sdma_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout  = mem[rp];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/sdma_burst_pick.sv
module sdma_burst_pick #(
    parameter int LEN_W       = 24,
    parameter int BEAT_BYTES  = 8,
    parameter int SMALL_BYTES = 512,
    parameter int WIDE_BYTES  = 2048,
    localparam int SMALL_BEATS = SMALL_BYTES / BEAT_BYTES,
    localparam int WIDE_BEATS  = WIDE_BYTES / BEAT_BYTES
) (
    input  logic [LEN_W-1:0] left,
    input  logic             wide,
    output logic [7:0]       beats_m1,
    output logic [LEN_W-1:0] bytes
);
    always_comb begin
        if (wide && (left >= LEN_W'(WIDE_BYTES))) begin
            beats_m1 = 8'(WIDE_BEATS - 1);
            bytes    = LEN_W'(WIDE_BYTES);
        end else begin
            beats_m1 = 8'(SMALL_BEATS - 1);
            bytes    = LEN_W'(SMALL_BYTES);
        end
    end
endmodule

// File: rtl/sector_dma.sv
module sector_dma #(
    parameter int ADDR_W      = 32,
    parameter int MEM_W       = 64,
    parameter int LINK_W      = 32,
    parameter int LEN_W       = 24,
    parameter int FIFO_DEPTH  = 256,
    parameter int SMALL_BYTES = 512,
    parameter int WIDE_BYTES  = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_bytes,
    input  logic              req_to_mem,
    input  logic              req_wide,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] m_araddr,
    output logic [7:0]        m_arlen,
    output logic              m_arvalid,
    input  logic              m_arready,
    input  logic [MEM_W-1:0]  m_rdata,
    input  logic              m_rlast,
    input  logic              m_rvalid,
    output logic              m_rready,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic [7:0]        m_awlen,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [MEM_W-1:0]  m_wdata,
    output logic              m_wlast,
    output logic              m_wvalid,
    input  logic              m_wready,
    input  logic              m_bvalid,
    output logic              m_bready,
    output logic [LINK_W-1:0] lk_out_data,
    output logic              lk_out_valid,
    input  logic              lk_out_ready,
    input  logic [LINK_W-1:0] lk_in_data,
    input  logic              lk_in_valid,
    output logic              lk_in_ready
);
    import sdma_pkg::*;

    localparam int BEAT_BYTES = MEM_W / 8;
    localparam int WORD_SHIFT = $clog2(LINK_W / 8);
    localparam int CW         = $clog2(FIFO_DEPTH) + 1;

    sdma_state_t       state, state_nx;
    logic              to_mem, wide;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  left, in_left, bbytes, pick_bytes;
    logic [7:0]        blen, beat_cnt, pick_m1;
    logic              out_hi, pack_hi;
    logic [LINK_W-1:0] pack_lo;

    logic              fe_push, fe_pop, fe_full, fe_empty;
    logic [MEM_W-1:0]  fe_dout;
    logic [CW-1:0]     fe_count, fe_room, need;
    logic              st_push, st_pop, st_full, st_empty;
    logic [MEM_W-1:0]  st_dout;
    logic [CW-1:0]     st_count;
    logic              can_go, addr_hs, in_hs;

    sdma_burst_pick #(
        .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES),
        .SMALL_BYTES(SMALL_BYTES), .WIDE_BYTES(WIDE_BYTES)
    ) pick_i (
        .left(left), .wide(wide), .beats_m1(pick_m1), .bytes(pick_bytes)
    );

    sdma_fifo #(.W(MEM_W), .DEPTH(FIFO_DEPTH)) fetch_q (
        .clk(clk), .rst_n(rst_n), .push(fe_push), .din(m_rdata), .pop(fe_pop),
        .dout(fe_dout), .count(fe_count), .full(fe_full), .empty(fe_empty)
    );

    sdma_fifo #(.W(MEM_W), .DEPTH(FIFO_DEPTH)) store_q (
        .clk(clk), .rst_n(rst_n), .push(st_push), .din({lk_in_data, pack_lo}), .pop(st_pop),
        .dout(st_dout), .count(st_count), .full(st_full), .empty(st_empty)
    );

    assign fe_room = CW'(FIFO_DEPTH) - fe_count;
    assign need    = CW'(pick_m1) + 1'b1;
    assign can_go  = to_mem ? (st_count >= need) : (fe_room >= need);
    assign addr_hs = (m_arvalid && m_arready) || (m_awvalid && m_awready);
    assign in_hs   = lk_in_valid && lk_in_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req_valid) state_nx = S_PLAN;
            S_PLAN: begin
                if (left == '0)  state_nx = to_mem ? S_FINISH : S_DRAIN;
                else if (can_go) state_nx = S_ADDR;
            end
            S_ADDR:   if (addr_hs) state_nx = to_mem ? S_WDATA : S_RDATA;
            S_RDATA:  if (fe_push && m_rlast) state_nx = S_PLAN;
            S_WDATA:  if (st_pop && (beat_cnt == blen)) state_nx = S_WRESP;
            S_WRESP:  if (m_bvalid) state_nx = (left == '0) ? S_FINISH : S_PLAN;
            S_DRAIN:  if (fe_empty) state_nx = S_FINISH;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy         = (state != S_IDLE);
        done         = (state == S_FINISH);
        m_arvalid    = (state == S_ADDR) && !to_mem;
        m_awvalid    = (state == S_ADDR) && to_mem;
        m_araddr     = cur_addr;
        m_awaddr     = cur_addr;
        m_arlen      = blen;
        m_awlen      = blen;
        m_rready     = (state == S_RDATA);
        m_wvalid     = (state == S_WDATA);
        m_wlast      = m_wvalid && (beat_cnt == blen);
        m_wdata      = st_dout;
        m_bready     = (state == S_WRESP);
        lk_out_valid = !fe_empty;
        lk_out_data  = out_hi ? fe_dout[MEM_W-1:LINK_W] : fe_dout[LINK_W-1:0];
        lk_in_ready  = busy && to_mem && (in_left != '0) && !st_full;
    end

    assign fe_push = m_rvalid && m_rready;
    assign fe_pop  = lk_out_valid && lk_out_ready && out_hi;
    assign st_push = in_hs && pack_hi;
    assign st_pop  = m_wvalid && m_wready;

    // burst and stream datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_mem   <= 1'b0;
            wide     <= 1'b0;
            cur_addr <= '0;
            left     <= '0;
            in_left  <= '0;
            blen     <= '0;
            bbytes   <= '0;
            beat_cnt <= '0;
            out_hi   <= 1'b0;
            pack_hi  <= 1'b0;
            pack_lo  <= '0;
        end else begin
            if (state == S_IDLE && req_valid) begin
                to_mem   <= req_to_mem;
                wide     <= req_wide;
                cur_addr <= req_addr;
                left     <= req_bytes;
                in_left  <= req_to_mem ? (req_bytes >> WORD_SHIFT) : '0;
            end else if (in_hs) begin
                in_left <= in_left - 1'b1;
            end
            if (state == S_PLAN && can_go) begin
                blen   <= pick_m1;
                bbytes <= pick_bytes;
            end
            if (state == S_ADDR && addr_hs) begin
                cur_addr <= cur_addr + ADDR_W'(bbytes);
                left     <= left - bbytes;
                beat_cnt <= '0;
            end
            if (st_pop) beat_cnt <= beat_cnt + 1'b1;
            if (lk_out_valid && lk_out_ready) out_hi <= !out_hi;
            if (in_hs) begin
                pack_hi <= !pack_hi;
                if (!pack_hi) pack_lo <= lk_in_data;
            end
        end
    end

    // R10
    ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr) && $stable(m_arlen));
    // R10
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr) && $stable(m_awlen));
    // R2
    arlen_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid |-> (m_arlen == 8'(SMALL_BYTES / BEAT_BYTES - 1)) || (m_arlen == 8'(WIDE_BYTES / BEAT_BYTES - 1)));
    // R3
    rd_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid |-> (fe_room >= CW'(m_arlen) + 1'b1));
    // R4
    wr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (st_count >= CW'(m_awlen) + 1'b1));
    // R6
    wlast_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid && m_wready && m_wlast |=> !m_wvalid);
    // R7
    wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && to_mem |-> $past(m_bvalid && m_bready));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/sector_dma_tb.sv
module sector_dma_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_to_mem = 1'b0, req_wide = 1'b0;
    logic [31:0] req_addr = '0;
    logic [23:0] req_bytes = '0;
    logic        busy, done;
    logic [31:0] m_araddr, m_awaddr;
    logic [7:0]  m_arlen, m_awlen;
    logic        m_arvalid, m_rready, m_awvalid, m_wlast, m_wvalid, m_bready;
    logic        m_arready = 1'b0, m_rlast = 1'b0, m_rvalid = 1'b0;
    logic        m_awready = 1'b0, m_wready = 1'b0, m_bvalid = 1'b0;
    logic [63:0] m_rdata = '0;
    logic [63:0] m_wdata;
    logic [31:0] lk_out_data;
    logic        lk_out_valid, lk_in_ready;
    logic        lk_out_ready = 1'b0, lk_in_valid = 1'b0;
    logic [31:0] lk_in_data = '0;

    always #(CLK_PERIOD / 2) clk = !clk;

    sector_dma dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_bytes(req_bytes), .req_to_mem(req_to_mem), .req_wide(req_wide),
        .busy(busy), .done(done),
        .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rlast(m_rlast), .m_rvalid(m_rvalid), .m_rready(m_rready),
        .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wlast(m_wlast), .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bvalid(m_bvalid), .m_bready(m_bready),
        .lk_out_data(lk_out_data), .lk_out_valid(lk_out_valid), .lk_out_ready(lk_out_ready),
        .lk_in_data(lk_in_data), .lk_in_valid(lk_in_valid), .lk_in_ready(lk_in_ready)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus and stream models
    int          cyc = 0;
    logic [31:0] ar_log_a [16], aw_log_a [16];
    logic [7:0]  ar_log_l [16], aw_log_l [16];
    int          ar_n = 0, aw_n = 0, b_n = 0, done_n = 0;
    bit          r_active = 0, b_fire = 0, ar_pend = 0;
    logic [31:0] r_addr = '0, w_addr = '0, ar_pend_a = '0;
    int          r_beat = 0, r_len = 0, w_beat = 0, w_len = 0, b_wait = 0;
    bit          sink_en = 0, src_en = 0;
    int          words_out = 0, src_sent = 0, src_total = 0, need_words = 0;
    logic [31:0] out_base = '0, src_base = '0;

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (done) done_n++;
            // read data
            if (r_active) begin
                m_rvalid = (cyc % 4) != 1;
                m_rdata  = {r_addr + 32'(8 * r_beat) + 32'd4, r_addr + 32'(8 * r_beat)};
                m_rlast  = (r_beat == r_len);
                if (m_rvalid && m_rready) begin
                    if (r_beat == r_len) r_active = 0;
                    r_beat++;
                end
            end else begin
                m_rvalid = 1'b0;
                m_rlast  = 1'b0;
            end
            // read address, R10 hold check
            if (ar_pend) chk(m_arvalid && (m_araddr == ar_pend_a), "R10 AR held", 64'(m_araddr), 64'(ar_pend_a));
            m_arready = (cyc % 3) != 0;
            ar_pend   = m_arvalid && !m_arready;
            ar_pend_a = m_araddr;
            if (m_arvalid && m_arready) begin
                if (ar_n < 16) begin
                    ar_log_a[ar_n] = m_araddr;
                    ar_log_l[ar_n] = m_arlen;
                end
                ar_n++;
                r_active = 1;
                r_addr   = m_araddr;
                r_len    = int'(m_arlen);
                r_beat   = 0;
            end
            // write data
            m_wready = (cyc % 5) != 2;
            if (m_wvalid && m_wready) begin
                chk(m_wdata == {w_addr + 32'(8 * w_beat) + 32'd4, w_addr + 32'(8 * w_beat)},
                    "R5 write beat packing", m_wdata,
                    {w_addr + 32'(8 * w_beat) + 32'd4, w_addr + 32'(8 * w_beat)});
                chk(m_wlast == (w_beat == w_len), "R6 WLAST position", 64'(m_wlast), 64'(w_beat == w_len));
                if (w_beat == w_len) b_wait = 10;
                w_beat++;
            end
            // write address, R4 fill check
            m_awready = (cyc % 3) != 1;
            if (m_awvalid && m_awready) begin
                if (aw_n < 16) begin
                    aw_log_a[aw_n] = m_awaddr;
                    aw_log_l[aw_n] = m_awlen;
                end
                aw_n++;
                need_words += 2 * (int'(m_awlen) + 1);
                chk(src_sent >= need_words, "R4 AW waits for full burst", 64'(src_sent), 64'(need_words));
                w_addr = m_awaddr;
                w_len  = int'(m_awlen);
                w_beat = 0;
            end
            // write response
            if (b_fire) begin
                m_bvalid = 1'b0;
                b_fire   = 0;
            end
            if (b_wait > 0) begin
                b_wait--;
                if (b_wait == 0) m_bvalid = 1'b1;
            end
            if (m_bvalid && m_bready) begin
                b_n++;
                b_fire = 1;
            end
            // outgoing stream sink
            lk_out_ready = sink_en && ((cyc % 7) != 3);
            if (lk_out_valid && lk_out_ready) begin
                chk(lk_out_data == out_base + 32'(4 * words_out), "R5 read word order",
                    64'(lk_out_data), 64'(out_base + 32'(4 * words_out)));
                words_out++;
            end
            // incoming stream source
            lk_in_valid = src_en && (src_sent < src_total) && ((cyc % 3) == 0);
            lk_in_data  = src_base + 32'(4 * src_sent);
            if (lk_in_valid && lk_in_ready) src_sent++;
        end
    end

    task automatic clear_logs();
        ar_n = 0; aw_n = 0; b_n = 0; done_n = 0;
        words_out = 0; src_sent = 0; src_total = 0; need_words = 0;
        sink_en = 0; src_en = 0;
    endtask

    task automatic start(input logic [31:0] a, input int len, input bit wr, input bit wd);
        @(negedge clk); #1;
        req_addr = a; req_bytes = 24'(len); req_to_mem = wr; req_wide = wd; req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int max, output bit seen);
        seen = 0;
        for (int i = 0; i < max; i++) begin
            @(negedge clk); #1;
            if (done) begin
                seen = 1;
                break;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(!busy && !done, "R1 idle after reset", 64'({busy, done}), 64'(0));
        chk(!m_arvalid && !m_awvalid, "R1 no address valid", 64'({m_arvalid, m_awvalid}), 64'(0));
        chk(!lk_out_valid && !lk_in_ready, "R1 stream quiet", 64'({lk_out_valid, lk_in_ready}), 64'(0));
    endtask

    task automatic t_read_wide();
        bit seen;
        clear_logs(); sink_en = 1; out_base = 32'h0000_1000;
        start(32'h0000_1000, 2560, 1'b0, 1'b1);
        wait_done(8000, seen);
        chk(seen, "R8 read done seen", 64'(seen), 64'(1));
        chk(words_out == 640, "R8 all words out at done", 64'(words_out), 64'(640));
        chk(ar_n == 2, "R2 read burst count", 64'(ar_n), 64'(2));
        chk(ar_log_a[0] == 32'h1000 && ar_log_l[0] == 8'd255, "R2 first wide burst", {ar_log_a[0], 24'd0, ar_log_l[0]}, {32'h1000, 32'd255});
        chk(ar_log_a[1] == 32'h1800 && ar_log_l[1] == 8'd63, "R2 tail small burst", {ar_log_a[1], 24'd0, ar_log_l[1]}, {32'h1800, 32'd63});
        @(negedge clk); #1;
        chk(!done && !busy, "R9 done one cycle", 64'({done, busy}), 64'(0));
    endtask

    task automatic t_read_stall();
        bit seen;
        clear_logs(); out_base = 32'h0002_0000;
        start(32'h0002_0000, 2560, 1'b0, 1'b1);
        repeat (800) @(negedge clk);
        #1;
        chk(ar_n == 1, "R3 second AR held back while fetch FIFO full", 64'(ar_n), 64'(1));
        chk(lk_out_valid, "R3 data waiting", 64'(lk_out_valid), 64'(1));
        sink_en = 1;
        wait_done(8000, seen);
        chk(seen && words_out == 640, "R8 stalled read completes", 64'(words_out), 64'(640));
        chk(ar_n == 2, "R3 second AR after room", 64'(ar_n), 64'(2));
    endtask

    task automatic t_write(input logic [31:0] a, input int len, input bit wd,
                           input int exp_bursts, input logic [7:0] first_len);
        bit seen;
        clear_logs(); src_base = a; src_total = len / 4; src_en = 1;
        start(a, len, 1'b1, wd);
        wait_done(20000, seen);
        chk(seen, "R7 write done seen", 64'(seen), 64'(1));
        chk(b_n == exp_bursts, "R7 all responses before done", 64'(b_n), 64'(exp_bursts));
        chk(aw_n == exp_bursts, "R2 write burst count", 64'(aw_n), 64'(exp_bursts));
        chk(src_sent == len / 4, "R5 all link words taken", 64'(src_sent), 64'(len / 4));
        chk(aw_log_a[0] == a && aw_log_l[0] == first_len, "R2 first write burst", {aw_log_a[0], 24'd0, aw_log_l[0]}, {a, 24'd0, first_len});
        for (int i = 1; i < exp_bursts && i < 16; i++) begin
            chk(aw_log_a[i] == aw_log_a[i-1] + 32'((int'(aw_log_l[i-1]) + 1) * 8), "R2 contiguous write address",
                64'(aw_log_a[i]), 64'(aw_log_a[i-1] + 32'((int'(aw_log_l[i-1]) + 1) * 8)));
        end
        @(negedge clk); #1;
        chk(!done, "R9 write done one cycle", 64'(done), 64'(0));
    endtask

    task automatic t_busy_ignore();
        bit seen;
        clear_logs(); sink_en = 1; out_base = 32'h0000_4000;
        start(32'h0000_4000, 1024, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        start(32'h0000_9000, 512, 1'b1, 1'b1);
        wait_done(8000, seen);
        chk(ar_n == 2 && aw_n == 0, "R9 second request ignored", 64'({ar_n, aw_n}), 64'({32'd2, 32'd0}));
        chk(ar_log_a[1] == 32'h4200, "R2 narrow read steps 512", 64'(ar_log_a[1]), 64'(32'h4200));
        chk(words_out == 256, "R8 words of first request", 64'(words_out), 64'(256));
        repeat (20) @(negedge clk);
        #1;
        chk(!busy && done_n == 1, "R9 single completion", 64'({busy, 8'(done_n)}), 64'(1));
    endtask

    bit finished = 0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_wide();
        t_read_stall();
        t_write(32'h0000_3000, 1024, 1'b1, 2, 8'd63);
        t_write(32'h0000_8000, 2048, 1'b0, 4, 8'd63);
        t_write(32'h0001_0000, 2560, 1'b1, 2, 8'd255);
        t_busy_ignore();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule